// File: doc/BRIEF.md
# Parallel DAC Bus Command Sequencer

This block sits on the host side of a parallel, strobe-driven multichannel converter interface. It turns one-at-a-time commands (write a channel, write every channel in a burst, pulse the global load, read one channel back, and pulse the converter reset) into correctly timed pin activity. It drives the channel address, the write data with a separate output-enable for the host's bus drivers, and the chip-select, read/write, enable, load and reset strobes. It returns read data with a valid flag and raises a one-cycle done pulse when each command completes.

Every timing limit of the interface is a parameter given in nanoseconds. The block converts each one into a cycle count from the clock-period parameter, rounding up, so the same code meets the interface limits at any clock rate. The limits covered are enable low and high times, data hold after enable rises, access delay after an address change, bus turn-around delay and reset width. With the default 4 ns clock these counts are: enable low 10 cycles, enable high 10 cycles, access wait 40 cycles, bus release 38 cycles, reset 7 cycles.

Top module: `hbs_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, chip select, enable, load and reset strobes are high, read/write is low (write), output enable is low, address, write data and read data are zero, `done` and `rd_valid` are low and `cmd_ready` is high.
- R2: Op code 0 (single write) drives chip select and read/write low, puts the channel on the address and the data on the bus with output enable high, holds enable low for 10 cycles and then high for 10 cycles with address, data and chip select unchanged, then returns to idle with `done` high.
- R3: Op code 1 (burst write) writes channels 0 to 15 in ascending order, channel k taking bits [8k+7:8k] of `cmd_burst`. Each channel gets 10 enable-low cycles and then 10 enable-high cycles. Address and data change only on the cycle enable falls. Chip select and read/write stay low for the whole 320 cycles.
- R4: Op code 2 (load) drives the load strobe and enable low together for 10 cycles and then high for 10 cycles. Chip select stays high and output enable stays low throughout.
- R5: Op code 3 (read) drives read/write high and chip select low with output enable, enable and load inactive for 40 cycles. It samples `bus_din` at the end of the 40th cycle. It then raises chip select and keeps read/write high for 38 more cycles. Read/write returns low on the cycle `done` and `rd_valid` pulse, and `rd_data` holds the sample.
- R6: Op code 4 (reset) drives the reset strobe low for ceil(25/4) = 7 cycles with chip select, enable and load high. A later read of any channel returns zero.
- R7: `cmd_ready` is high only when idle. A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_valid` is ignored while busy. `done` is a one-cycle pulse in the first idle cycle after a command.
- R8: Op codes 5 to 7 are taken and completed with `done` in the next cycle, and no bus pin changes.
- R9: Output enable is never high while read/write is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Idle, command can be taken |
| cmd_op | input | 3 | Command code |
| cmd_chan | input | AW | Channel for single write and read |
| cmd_data | input | DW | Data for single write |
| cmd_burst | input | NCH*DW | Data for all channels in a burst |
| bus_addr | output | AW | Channel address to converter |
| bus_dout | output | DW | Write data to converter |
| bus_oe | output | 1 | Host data-bus driver enable |
| bus_din | input | DW | Read data from converter |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_en_n | output | 1 | Enable strobe, active low |
| bus_ld_n | output | 1 | Global load strobe, active low |
| bus_rs_n | output | 1 | Converter reset strobe, active low |
| rd_data | output | DW | Last read result |
| rd_valid | output | 1 | Read result valid pulse |
| done | output | 1 | Command complete pulse |

## Verification
A phase counter that is loaded wrongly or stops early shows up at the pins as a strobe edge one or more cycles off from the model. It is caught in the same cycle. A sampling point that is too early returns the bench's filler byte instead of channel data, which is seen at the done of that read. A wrong channel index in a burst writes data to the wrong place in the bench's converter model, so the later reads of channels 0 and 15 return the wrong byte. A state machine that leaves the bus driven during a read is flagged at the first cycle read/write is high.

// File: rtl/hbs_pkg.sv
// Shared types and helpers for the parallel bus sequencer.
// Assumes all timing values are positive integers in nanoseconds.
package hbs_pkg;

    // Command codes on cmd_op
    typedef enum logic [2:0] {
        OP_WRITE = 3'd0,
        OP_BURST = 3'd1,
        OP_LOAD  = 3'd2,
        OP_READ  = 3'd3,
        OP_RESET = 3'd4
    } op_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_LO,
        S_WR_HI,
        S_LD_LO,
        S_LD_HI,
        S_RD_ACC,
        S_RD_REL,
        S_RST_LO
    } state_e;

    // Bus strobe group, all registered together
    typedef struct packed {
        logic cs_n;
        logic rw;
        logic en_n;
        logic ld_n;
        logic rs_n;
        logic oe;
    } strb_t;

    localparam strb_t STRB_IDLE = '{cs_n: 1'b1, rw: 1'b0, en_n: 1'b1,
                                    ld_n: 1'b1, rs_n: 1'b1, oe: 1'b0};

    // Nanoseconds to cycles, rounded up, never below one
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hbs_timer.sv
// Phase timer: loaded with N-1, counts down to zero, so a phase lasts N cycles.
// Assumes the loaded value fits in W bits.
module hbs_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= val;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/hbs_chan_ctr.sv
// Burst channel index: cleared at burst start, stepped per channel.
// Assumes NCH channels numbered from zero.
module hbs_chan_ctr #(
    parameter int NCH = 16,
    parameter int AW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] idx,
    output logic [AW-1:0] idx_nxt,
    output logic          last
);
    localparam logic [AW-1:0] LAST_IDX = AW'(NCH - 1);

    // Hold the current burst channel
    always_ff @(posedge clk) begin
        if (!rst_n)   idx <= '0;
        else if (clr) idx <= '0;
        else if (inc) idx <= idx_nxt;
    end

    assign idx_nxt = idx + 1'b1;
    assign last    = (idx == LAST_IDX);
endmodule

// File: rtl/hbs_ctrl.sv
// Command state machine and registered bus pins.
// Assumes phase counts are at least one and the timer/counter follow its strobes
// with one cycle of latency.
module hbs_ctrl
    import hbs_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int DW    = 8,
    parameter int AW    = 4,
    parameter int TW    = 6,
    parameter int C_L   = 10,
    parameter int C_H   = 10,
    parameter int C_ACC = 40,
    parameter int C_REL = 38,
    parameter int C_RS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_chan,
    input  logic [DW-1:0]     cmd_data,
    input  logic [NCH*DW-1:0] cmd_burst,
    input  logic [DW-1:0]     bus_din,
    output strb_t             strb,
    output logic [AW-1:0]     addr,
    output logic [DW-1:0]     dout,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic              done,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    input  logic [AW-1:0]     ch_nxt,
    input  logic              ch_last,
    output logic              ch_clr,
    output logic              ch_inc
);
    localparam logic [TW-1:0] V_L   = TW'(C_L - 1);
    localparam logic [TW-1:0] V_H   = TW'(C_H - 1);
    localparam logic [TW-1:0] V_ACC = TW'(C_ACC - 1);
    localparam logic [TW-1:0] V_REL = TW'(C_REL - 1);
    localparam logic [TW-1:0] V_RS  = TW'(C_RS - 1);

    state_e            st_q, st_d;
    strb_t             strb_d;
    logic [AW-1:0]     addr_d;
    logic [DW-1:0]     dout_d, rdd_d;
    logic              done_d, rdv_d, burst_q, burst_d;
    logic [NCH*DW-1:0] bdat_q, bdat_d;

    // Next-state and next-pin decision for every phase
    always_comb begin
        st_d     = st_q;
        strb_d   = strb;
        addr_d   = addr;
        dout_d   = dout;
        rdd_d    = rd_data;
        done_d   = 1'b0;
        rdv_d    = 1'b0;
        burst_d  = burst_q;
        bdat_d   = bdat_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ch_clr   = 1'b0;
        ch_inc   = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_WRITE, OP_BURST: begin
                            st_d     = S_WR_LO;
                            strb_d   = '{cs_n: 1'b0, rw: 1'b0, en_n: 1'b0,
                                         ld_n: 1'b1, rs_n: 1'b1, oe: 1'b1};
                            tmr_load = 1'b1;
                            tmr_val  = V_L;
                            if (cmd_op == OP_BURST) begin
                                addr_d  = '0;
                                dout_d  = cmd_burst[DW-1:0];
                                bdat_d  = cmd_burst;
                                burst_d = 1'b1;
                                ch_clr  = 1'b1;
                            end else begin
                                addr_d  = cmd_chan;
                                dout_d  = cmd_data;
                                burst_d = 1'b0;
                            end
                        end
                        OP_LOAD: begin
                            st_d     = S_LD_LO;
                            strb_d   = '{cs_n: 1'b1, rw: 1'b0, en_n: 1'b0,
                                         ld_n: 1'b0, rs_n: 1'b1, oe: 1'b0};
                            tmr_load = 1'b1;
                            tmr_val  = V_L;
                        end
                        OP_READ: begin
                            st_d     = S_RD_ACC;
                            strb_d   = '{cs_n: 1'b0, rw: 1'b1, en_n: 1'b1,
                                         ld_n: 1'b1, rs_n: 1'b1, oe: 1'b0};
                            addr_d   = cmd_chan;
                            tmr_load = 1'b1;
                            tmr_val  = V_ACC;
                        end
                        OP_RESET: begin
                            st_d     = S_RST_LO;
                            strb_d   = '{cs_n: 1'b1, rw: 1'b0, en_n: 1'b1,
                                         ld_n: 1'b1, rs_n: 1'b0, oe: 1'b0};
                            tmr_load = 1'b1;
                            tmr_val  = V_RS;
                        end
                        default: done_d = 1'b1;
                    endcase
                end
            end
            S_WR_LO: begin
                if (tmr_zero) begin
                    st_d        = S_WR_HI;
                    strb_d.en_n = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = V_H;
                end
            end
            S_WR_HI: begin
                if (tmr_zero) begin
                    if (burst_q && !ch_last) begin
                        st_d        = S_WR_LO;
                        strb_d.en_n = 1'b0;
                        addr_d      = ch_nxt;
                        dout_d      = bdat_q[int'(ch_nxt)*DW +: DW];
                        ch_inc      = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = V_L;
                    end else begin
                        st_d   = S_IDLE;
                        strb_d = STRB_IDLE;
                        done_d = 1'b1;
                    end
                end
            end
            S_LD_LO: begin
                if (tmr_zero) begin
                    st_d        = S_LD_HI;
                    strb_d.en_n = 1'b1;
                    strb_d.ld_n = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = V_H;
                end
            end
            S_LD_HI: begin
                if (tmr_zero) begin
                    st_d   = S_IDLE;
                    strb_d = STRB_IDLE;
                    done_d = 1'b1;
                end
            end
            S_RD_ACC: begin
                if (tmr_zero) begin
                    st_d        = S_RD_REL;
                    rdd_d       = bus_din;
                    strb_d.cs_n = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = V_REL;
                end
            end
            S_RD_REL: begin
                if (tmr_zero) begin
                    st_d   = S_IDLE;
                    strb_d = STRB_IDLE;
                    done_d = 1'b1;
                    rdv_d  = 1'b1;
                end
            end
            S_RST_LO: begin
                if (tmr_zero) begin
                    st_d   = S_IDLE;
                    strb_d = STRB_IDLE;
                    done_d = 1'b1;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // Register state, pins and command payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            strb     <= STRB_IDLE;
            addr     <= '0;
            dout     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
            burst_q  <= 1'b0;
            bdat_q   <= '0;
        end else begin
            st_q     <= st_d;
            strb     <= strb_d;
            addr     <= addr_d;
            dout     <= dout_d;
            rd_data  <= rdd_d;
            rd_valid <= rdv_d;
            done     <= done_d;
            burst_q  <= burst_d;
            bdat_q   <= bdat_d;
        end
    end

    assign cmd_ready = (st_q == S_IDLE);
endmodule

// File: rtl/hbs_seq.sv
// Top of the parallel bus sequencer: derives cycle counts from the
// nanosecond limits and joins timer, burst counter and control.
// Assumes bus_din is stable by the end of the access wait.
module hbs_seq
    import hbs_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int DW        = 8,
    parameter int CLK_NS    = 4,
    parameter int T_ENL_NS  = 40,
    parameter int T_ENH_NS  = 40,
    parameter int T_DH_NS   = 10,
    parameter int T_ACC_NS  = 160,
    parameter int T_RWD_NS  = 120,
    parameter int T_REL_NS  = 150,
    parameter int T_RST_NS  = 25,
    localparam int AW       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_chan,
    input  logic [DW-1:0]     cmd_data,
    input  logic [NCH*DW-1:0] cmd_burst,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_oe,
    input  logic [DW-1:0]     bus_din,
    output logic              bus_cs_n,
    output logic              bus_rw,
    output logic              bus_en_n,
    output logic              bus_ld_n,
    output logic              bus_rs_n,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic              done
);
    localparam int C_L   = ns_to_cyc(T_ENL_NS, CLK_NS);
    localparam int C_H   = imax(ns_to_cyc(T_ENH_NS, CLK_NS), ns_to_cyc(T_DH_NS, CLK_NS));
    localparam int C_ACC = imax(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_RWD_NS, CLK_NS));
    localparam int C_REL = ns_to_cyc(T_REL_NS, CLK_NS);
    localparam int C_RS  = ns_to_cyc(T_RST_NS, CLK_NS);
    localparam int C_MAX = imax(imax(C_L, C_H), imax(imax(C_ACC, C_REL), C_RS));
    localparam int TW    = $clog2(C_MAX + 1);

    strb_t          strb;
    logic           tmr_zero, tmr_load;
    logic [TW-1:0]  tmr_val;
    logic [AW-1:0]  ch_idx, ch_nxt;
    logic           ch_last, ch_clr, ch_inc;

    hbs_timer #(.W(TW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    hbs_chan_ctr #(.NCH(NCH), .AW(AW)) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ch_clr),
        .inc    (ch_inc),
        .idx    (ch_idx),
        .idx_nxt(ch_nxt),
        .last   (ch_last)
    );

    hbs_ctrl #(
        .NCH(NCH), .DW(DW), .AW(AW), .TW(TW),
        .C_L(C_L), .C_H(C_H), .C_ACC(C_ACC), .C_REL(C_REL), .C_RS(C_RS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_op   (cmd_op),
        .cmd_chan (cmd_chan),
        .cmd_data (cmd_data),
        .cmd_burst(cmd_burst),
        .bus_din  (bus_din),
        .strb     (strb),
        .addr     (bus_addr),
        .dout     (bus_dout),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .done     (done),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .ch_nxt   (ch_nxt),
        .ch_last  (ch_last),
        .ch_clr   (ch_clr),
        .ch_inc   (ch_inc)
    );

    assign bus_cs_n = strb.cs_n;
    assign bus_rw   = strb.rw;
    assign bus_en_n = strb.en_n;
    assign bus_ld_n = strb.ld_n;
    assign bus_rs_n = strb.rs_n;
    assign bus_oe   = strb.oe;

    // ch_idx is consumed through ch_last and ch_nxt
    logic unused_idx;
    assign unused_idx = ^ch_idx;
endmodule

// File: rtl/hbs_seq_chk.sv
// Protocol checker for the bus sequencer pins; attached by bind.
// Assumes synchronous active-low reset on rst_n.
module hbs_seq_chk #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_ready,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_dout,
    input logic          bus_oe,
    input logic          bus_cs_n,
    input logic          bus_rw,
    input logic          bus_en_n,
    input logic          bus_ld_n,
    input logic          bus_rs_n,
    input logic          rd_valid,
    input logic          done
);
    // R9
    oe_rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !bus_rw);

    // R4
    ld_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ld_n |-> (bus_cs_n && !bus_oe));

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_en_n) && !bus_cs_n && !bus_rw) |-> ($stable(bus_dout) && $stable(bus_addr)));

    // R5
    rd_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rw) |-> (!bus_oe && !bus_cs_n && bus_en_n && bus_ld_n));

    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rw) |-> (bus_cs_n && done && rd_valid));

    // R5
    rdv_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (done && cmd_ready));

    // R6
    rst_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rs_n |-> (bus_cs_n && bus_en_n && bus_ld_n));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);
endmodule

bind hbs_seq hbs_seq_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ready(cmd_ready),
    .bus_addr (bus_addr),
    .bus_dout (bus_dout),
    .bus_oe   (bus_oe),
    .bus_cs_n (bus_cs_n),
    .bus_rw   (bus_rw),
    .bus_en_n (bus_en_n),
    .bus_ld_n (bus_ld_n),
    .bus_rs_n (bus_rs_n),
    .rd_valid (rd_valid),
    .done     (done)
);

// File: tb/hbs_seq_bench.sv
`timescale 1ns/1ps
module hbs_seq_bench;
    localparam int NCH = 16;
    localparam int DW  = 8;
    localparam int AW  = 4;
    localparam int CK  = 4;
    localparam int EL  = (40 + CK - 1) / CK;
    localparam int EHA = (40 + CK - 1) / CK;
    localparam int EHB = (10 + CK - 1) / CK;
    localparam int EH  = (EHA > EHB) ? EHA : EHB;
    localparam int ACA = (160 + CK - 1) / CK;
    localparam int ACB = (120 + CK - 1) / CK;
    localparam int ACC = (ACA > ACB) ? ACA : ACB;
    localparam int REL = (150 + CK - 1) / CK;
    localparam int RSC = (25 + CK - 1) / CK;
    localparam logic [7:0] JUNK = 8'hEE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_chan = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [NCH*DW-1:0] cmd_burst = '0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout, bus_din, rd_data;
    logic bus_oe, bus_cs_n, bus_rw, bus_en_n, bus_ld_n, bus_rs_n, rd_valid, done;

    always #2 clk = ~clk;

    hbs_seq u_hbs_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_data(cmd_data), .cmd_burst(cmd_burst),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
        .bus_cs_n(bus_cs_n), .bus_rw(bus_rw), .bus_en_n(bus_en_n), .bus_ld_n(bus_ld_n),
        .bus_rs_n(bus_rs_n), .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
    );

    // Converter model driven only from the pins
    logic [7:0] dev_mem [NCH];
    logic       prev_en_n = 1'b1;
    logic [3:0] prev_addr = '0;
    int         acc_cnt = 0;

    initial for (int i = 0; i < NCH; i++) dev_mem[i] = '0;

    always @(posedge clk) begin
        if (!bus_rs_n) begin
            for (int i = 0; i < NCH; i++) dev_mem[i] <= '0;
        end else if (!prev_en_n && bus_en_n && !bus_cs_n && !bus_rw) begin
            dev_mem[bus_addr] <= bus_dout;
        end
        prev_en_n <= bus_en_n;
        prev_addr <= bus_addr;
        if (bus_cs_n || !bus_rw)      acc_cnt <= 0;
        else if (bus_addr != prev_addr) acc_cnt <= 1;
        else                           acc_cnt <= acc_cnt + 1;
    end

    assign bus_din = (!bus_cs_n && bus_rw && acc_cnt >= ACC - 1) ? dev_mem[bus_addr] : JUNK;

    // Expected pin picture per cycle
    typedef struct packed {
        logic cs_n, rw, en_n, ld_n, rs_n, oe;
        logic [3:0] addr;
        logic [7:0] dout;
        logic done, rdv;
        logic [7:0] rdd;
        logic ready;
    } pin_t;

    pin_t  exp_q[$];
    string tag_q[$];
    string idle_tag = "R1";
    logic [3:0] m_addr = '0;
    logic [7:0] m_dout = '0;
    logic [7:0] m_rdd  = '0;
    logic [7:0] exp_mem [NCH];
    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    initial for (int i = 0; i < NCH; i++) exp_mem[i] = '0;

    task automatic push(input logic cs_n, rw, en_n, ld_n, rs_n, oe,
                        input logic dn, rv, rdy, input string tg);
        pin_t e;
        e = '{cs_n: cs_n, rw: rw, en_n: en_n, ld_n: ld_n, rs_n: rs_n, oe: oe,
              addr: m_addr, dout: m_dout, done: dn, rdv: rv, rdd: m_rdd, ready: rdy};
        exp_q.push_back(e);
        tag_q.push_back(tg);
    endtask

    // One cycle: compare all outputs against the model at the falling edge
    task automatic step();
        pin_t  a, e;
        string t;
        @(negedge clk);
        cyc++;
        a = '{cs_n: bus_cs_n, rw: bus_rw, en_n: bus_en_n, ld_n: bus_ld_n, rs_n: bus_rs_n,
              oe: bus_oe, addr: bus_addr, dout: bus_dout, done: done, rdv: rd_valid,
              rdd: rd_data, ready: cmd_ready};
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = '{cs_n: 1'b1, rw: 1'b0, en_n: 1'b1, ld_n: 1'b1, rs_n: 1'b1, oe: 1'b0,
                  addr: m_addr, dout: m_dout, done: 1'b0, rdv: 1'b0, rdd: m_rdd, ready: 1'b1};
            t = idle_tag;
        end
        n_run++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", t, cyc, a, e);
        end
    endtask

    task automatic wait_ready();
        do step(); while (!(cmd_ready === 1'b1 && exp_q.size() == 0));
    endtask

    task automatic launch(input logic [2:0] op, input logic [3:0] ch, input logic [7:0] d);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_chan  = ch;
        cmd_data  = d;
    endtask

    task automatic finish_launch();
        step();
        cmd_valid = 1'b0;
    endtask

    // R2 single write
    task automatic do_write(input logic [3:0] ch, input logic [7:0] d);
        wait_ready();
        launch(3'd0, ch, d);
        m_addr = ch; m_dout = d; exp_mem[ch] = d;
        repeat (EL) push(0, 0, 0, 1, 1, 1, 0, 0, 0, "R2");
        repeat (EH) push(0, 0, 1, 1, 1, 1, 0, 0, 0, "R2");
        push(1, 0, 1, 1, 1, 0, 1, 0, 1, "R2");
        finish_launch();
    endtask

    // R3 burst of all channels
    task automatic do_burst();
        logic [NCH*DW-1:0] v;
        for (int k = 0; k < NCH; k++) v[k*DW +: DW] = 8'(k * 37 + 5);
        wait_ready();
        launch(3'd1, 4'd9, 8'h00);
        cmd_burst = v;
        for (int k = 0; k < NCH; k++) begin
            m_addr = 4'(k); m_dout = v[k*DW +: DW]; exp_mem[k] = v[k*DW +: DW];
            repeat (EL) push(0, 0, 0, 1, 1, 1, 0, 0, 0, "R3");
            repeat (EH) push(0, 0, 1, 1, 1, 1, 0, 0, 0, "R3");
        end
        push(1, 0, 1, 1, 1, 0, 1, 0, 1, "R3");
        finish_launch();
    endtask

    // R4 global load
    task automatic do_load();
        wait_ready();
        launch(3'd2, 4'd5, 8'h77);
        repeat (EL) push(1, 0, 0, 0, 1, 0, 0, 0, 0, "R4");
        repeat (EH) push(1, 0, 1, 1, 1, 0, 0, 0, 0, "R4");
        push(1, 0, 1, 1, 1, 0, 1, 0, 1, "R4");
        finish_launch();
    endtask

    // R5 readback, tagged by the requirement it serves
    task automatic do_read(input logic [3:0] ch, input string tg);
        wait_ready();
        launch(3'd3, ch, 8'h99);
        m_addr = ch;
        repeat (ACC) push(0, 1, 1, 1, 1, 0, 0, 0, 0, tg);
        m_rdd = exp_mem[ch];
        repeat (REL) push(1, 1, 1, 1, 1, 0, 0, 0, 0, tg);
        push(1, 0, 1, 1, 1, 0, 1, 1, 1, tg);
        finish_launch();
    endtask

    // R6 converter reset
    task automatic do_reset();
        wait_ready();
        launch(3'd4, 4'd2, 8'h11);
        repeat (RSC) push(1, 0, 1, 1, 0, 0, 0, 0, 0, "R6");
        for (int i = 0; i < NCH; i++) exp_mem[i] = '0;
        push(1, 0, 1, 1, 1, 0, 1, 0, 1, "R6");
        finish_launch();
    endtask

    // R8 unassigned op code
    task automatic do_undef(input logic [2:0] op);
        wait_ready();
        launch(op, 4'd12, 8'h42);
        push(1, 0, 1, 1, 1, 0, 1, 0, 1, "R8");
        finish_launch();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog expired at cycle %0d: actual busy expected idle", cyc);
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (4) step();
        rst_n = 1'b1;
        repeat (2) step();
        idle_tag = "R7";

        do_write(4'd3, 8'hA5);
        do_read(4'd3, "R5");
        do_burst();
        do_read(4'd0, "R3");
        do_read(4'd15, "R3");
        do_load();
        do_write(4'd15, 8'h3C);
        do_load();
        do_read(4'd15, "R5");
        do_undef(3'd5);
        do_undef(3'd7);
        do_undef(3'd6);
        do_write(4'd7, 8'h81);
        // R7: requests while busy must be ignored
        do_read(4'd7, "R7");
        launch(3'd4, 4'd1, 8'h00);
        repeat (20) step();
        cmd_valid = 1'b0;
        do_read(4'd3, "R7");
        do_reset();
        do_read(4'd3, "R6");
        do_read(4'd7, "R6");
        wait_ready();
        repeat (3) step();
        summary();
        $finish;
    end
endmodule